// File: doc/BRIEF.md
# Dual-Mode Programmable Interval Timer

This block holds two timers for a microcontroller's peripheral area. Timer 0 owns a count register and a modulus register. In one-shot mode each of the two registers drives its own independent down-counting delay, and each delay has its own interrupt line. In interval mode only the modulus is used, as a period that reloads automatically. Timer 1 owns a single modulus register that acts as its period. Every time a timer 1 period ends, the block raises two separate interrupt requests.

All timing is measured in system clock cycles. One timer tick lasts the programmed prescale factor times a divider, and that divider depends on the mode. A one-shot channel divides by 12 or by 128. An interval channel divides by 6 or by 128. Software programs the timers through a single write port that carries a register select and a data word. Interrupt masking and priority are left to the interrupt controller that sits outside the block.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset all channels are stopped and all four interrupt outputs are low.
- R2: Register select 2 writes the timer 0 control register, and select 0 writes the count register. Control bit 0 = 1 selects one-shot mode. With bit 7 = 1 in one-shot mode, `irq_t0a` pulses once, exactly P·N·D cycles after the clock edge that took the control write. Here P is the prescale factor, N is the count register, and D is 128 when bit 6 is set and 12 otherwise.
- R3: Select 1 writes the timer 0 modulus. In one-shot mode, control bit 5 starts a second delay of P·M·D cycles that ends with one pulse on `irq_t0b`. Here M is the modulus, and D is 128 when bit 4 is set and 12 otherwise. This delay runs independently of the `irq_t0a` delay, and the two may end in the same cycle.
- R4: Control bit 0 = 0 selects interval mode. In interval mode, bit 7 makes `irq_t0a` pulse every P·M·D cycles, with no drift. Here D is 128 when bit 6 is set and 6 otherwise. `irq_t0b` stays silent in this mode.
- R5: A start request whose count or modulus is zero does not start the channel, and no interrupt follows.
- R6: A control write that clears a start bit stops that channel from its write edge on. If that edge coincides with an expiry, the write wins and no pulse is produced.
- R7: Select 4 writes the timer 1 control register, which keeps only bits 7:6. Select 3 writes the timer 1 modulus. With bit 7 set, `irq_t1a` and `irq_t1b` pulse together every P·M1·D cycles. D is 128 when bit 6 is set and 6 otherwise.
- R8: A write that takes the timer 1 modulus from zero to a nonzero value starts timer 1 at that edge if the stored bit 7 is set. The modulus is copied into the count at that point.
- R9: Every interrupt output is a single-cycle pulse.
- R10: Writing a nonzero modulus over a nonzero modulus does not restart a running interval channel. The new value first takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prescale | input | PW | Prescale factor P (a value of 0 acts as 1) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 count0, 1 mod0, 2 ctl0, 3 mod1, 4 ctl1 |
| wr_data | input | CW | Write data; control writes use bits 7:0 |
| irq_t0a | output | 1 | Timer 0 first-channel / interval interrupt pulse |
| irq_t0b | output | 1 | Timer 0 second-channel interrupt pulse |
| irq_t1a | output | 1 | Timer 1 period interrupt pulse, first request |
| irq_t1b | output | 1 | Timer 1 period interrupt pulse, second request |

## Verification
Two activities can land on the same clock edge: a channel reaching the end of its count, and a control or modulus write aimed at that same channel. The bench computes the expiry cycle of a running interval channel. It then times a stop write, and separately a restart write, so that the write is taken on exactly that edge. In both cases it expects no pulse at that edge, and for the restart it expects the first pulse one full period later. The same alignment is used for a timer 1 modulus write in mid-period, which must change the next period without moving the current expiry.

// File: rtl/dual_interval_timer.sv
`timescale 1ns/1ps
module dual_interval_timer #(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] prescale,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic          irq_t0a,
  output logic          irq_t0b,
  output logic          irq_t1a,
  output logic          irq_t1b
);
  localparam int DW  = 8;
  localparam int UW  = PW + DW;
  localparam int NCH = 3;
  localparam logic [2:0] SEL_CNT0 = 3'd0;
  localparam logic [2:0] SEL_MOD0 = 3'd1;
  localparam logic [2:0] SEL_CTL0 = 3'd2;
  localparam logic [2:0] SEL_MOD1 = 3'd3;
  localparam logic [2:0] SEL_CTL1 = 3'd4;
  localparam logic [DW-1:0] DIV_SLOW = DW'(128);
  localparam logic [DW-1:0] DIV_OS   = DW'(12);
  localparam logic [DW-1:0] DIV_IV   = DW'(6);

  logic [CW-1:0] cnt0_q, mod0_q, mod1_q;
  logic [1:0]    ctl1_q;
  logic [NCH-1:0] run_v, irq_v;

  logic          wctl0, wctl1, wmod1;
  logic [NCH-1:0] st, sp, np;
  logic [CW-1:0] ld [NCH];
  logic [DW-1:0] nd [NCH];
  logic [PW-1:0] pre_eff;

  assign wctl0   = wr_en && wr_sel == SEL_CTL0;
  assign wctl1   = wr_en && wr_sel == SEL_CTL1;
  assign wmod1   = wr_en && wr_sel == SEL_MOD1;
  assign pre_eff = (prescale == '0) ? PW'(1) : prescale;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt0_q <= '0;
      mod0_q <= '0;
      mod1_q <= '0;
      ctl1_q <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CNT0: cnt0_q <= wr_data;
        SEL_MOD0: mod0_q <= wr_data;
        SEL_MOD1: mod1_q <= wr_data;
        SEL_CTL1: ctl1_q <= wr_data[7:6];
        default: ;
      endcase
    end
  end

  always_comb begin
    st = '0;
    sp = '0;
    np = 3'b100;
    for (int i = 0; i < NCH; i++) begin
      ld[i] = '0;
      nd[i] = DIV_OS;
    end
    if (wctl0) begin
      if (wr_data[0]) begin
        st[0] = wr_data[7] && cnt0_q != '0;
        sp[0] = !st[0];
        ld[0] = cnt0_q;
        nd[0] = wr_data[6] ? DIV_SLOW : DIV_OS;
        st[1] = wr_data[5] && mod0_q != '0;
        sp[1] = !st[1];
        ld[1] = mod0_q;
        nd[1] = wr_data[4] ? DIV_SLOW : DIV_OS;
      end else begin
        st[0] = wr_data[7] && mod0_q != '0;
        sp[0] = !st[0];
        ld[0] = mod0_q;
        nd[0] = wr_data[6] ? DIV_SLOW : DIV_IV;
        np[0] = 1'b1;
        sp[1] = 1'b1;
      end
    end
    if (wctl1) begin
      st[2] = wr_data[7] && mod1_q != '0;
      sp[2] = !st[2];
      ld[2] = mod1_q;
      nd[2] = wr_data[6] ? DIV_SLOW : DIV_IV;
    end else if (wmod1 && mod1_q == '0 && wr_data != '0 && ctl1_q[1]) begin
      st[2] = 1'b1;
      ld[2] = wr_data;
      nd[2] = ctl1_q[0] ? DIV_SLOW : DIV_IV;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic          run_q, per_q, irq_q;
    logic [DW-1:0] div_q;
    logic [CW-1:0] rem_q, reload;
    logic [UW-1:0] frac_q, unit_m1;

    assign reload  = (g == 2) ? mod1_q : mod0_q;
    assign unit_m1 = UW'(pre_eff) * UW'(div_q) - UW'(1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run_q  <= 1'b0;
        per_q  <= 1'b0;
        irq_q  <= 1'b0;
        div_q  <= DIV_OS;
        rem_q  <= '0;
        frac_q <= '0;
      end else begin
        irq_q <= 1'b0;
        if (st[g]) begin
          run_q  <= 1'b1;
          per_q  <= np[g];
          div_q  <= nd[g];
          rem_q  <= ld[g];
          frac_q <= '0;
        end else if (sp[g]) begin
          run_q <= 1'b0;
        end else if (run_q) begin
          if (frac_q == unit_m1) begin
            frac_q <= '0;
            if (rem_q == CW'(1)) begin
              irq_q <= 1'b1;
              if (per_q && reload != '0) rem_q <= reload;
              else run_q <= 1'b0;
            end else begin
              rem_q <= rem_q - CW'(1);
            end
          end else begin
            frac_q <= frac_q + UW'(1);
          end
        end
      end
    end

    assign run_v[g] = run_q;
    assign irq_v[g] = irq_q;
  end

  assign irq_t0a = irq_v[0];
  assign irq_t0b = irq_v[1];
  assign irq_t1a = irq_v[2];
  assign irq_t1b = irq_v[2];
endmodule

module dual_interval_timer_checks #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_sel,
  input logic [CW-1:0] wr_data,
  input logic [CW-1:0] cnt0_q,
  input logic [CW-1:0] mod1_q,
  input logic [1:0]    ctl1_q,
  input logic [2:0]    run_v,
  input logic          irq_t0a,
  input logic          irq_t0b,
  input logic          irq_t1a,
  input logic          irq_t1b
);
  assert_pulse_t0a_R9: assert property (@(posedge clk) disable iff (!rst_n) irq_t0a |=> !irq_t0a);
  assert_pulse_t0b_R9: assert property (@(posedge clk) disable iff (!rst_n) irq_t0b |=> !irq_t0b);
  assert_pulse_t1a_R9: assert property (@(posedge clk) disable iff (!rst_n) irq_t1a |=> !irq_t1a);
  assert_pulse_t1b_R9: assert property (@(posedge clk) disable iff (!rst_n) irq_t1b |=> !irq_t1b);

  assert_fire_running_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_t0a |-> $past(run_v[0]));

  assert_zero_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd2 && wr_data[0] && wr_data[7] && cnt0_q == '0) |=> !run_v[0]);

  assert_stop_now_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd2 && !wr_data[7]) |=> (!run_v[0] && !irq_t0a));

  assert_ctl1_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd4) |=> ctl1_q == $past(wr_data[7:6]));

  assert_t1_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd3 && mod1_q == '0 && wr_data != '0 && ctl1_q[1]) |=> run_v[2]);
endmodule

bind dual_interval_timer dual_interval_timer_checks #(.CW(CW)) u_checks (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .cnt0_q(cnt0_q), .mod1_q(mod1_q), .ctl1_q(ctl1_q), .run_v(run_v),
  .irq_t0a(irq_t0a), .irq_t0b(irq_t0b), .irq_t1a(irq_t1a), .irq_t1b(irq_t1b)
);

// File: tb/dual_interval_timer_bench.sv
`timescale 1ns/1ps
module dual_interval_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] prescale = 8'd1;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic irq_t0a, irq_t0b, irq_t1a, irq_t1b;

  dual_interval_timer u_dual_interval_timer (
    .clk(clk), .rst_n(rst_n), .prescale(prescale), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .irq_t0a(irq_t0a), .irq_t0b(irq_t0b), .irq_t1a(irq_t1a), .irq_t1b(irq_t1b)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int pc [4];
  int last [4];
  logic [3:0] prevv = '0;
  int wide = 0, pairerr = 0;
  int nchk = 0, nerr = 0, wcyc = 0;
  bit done = 0;

  always @(negedge clk) begin
    logic [3:0] iv;
    iv = {irq_t1b, irq_t1a, irq_t0b, irq_t0a};
    if (rst_n) begin
      for (int i = 0; i < 4; i++) begin
        if (iv[i]) begin
          pc[i]++;
          last[i] = cyc;
          if (prevv[i]) wide++;
        end
      end
      if (irq_t1a != irq_t1b) pairerr++;
    end
    prevv = iv;
  end

  function automatic int os_div(bit b); return b ? 128 : 12; endfunction
  function automatic int iv_div(bit b); return b ? 128 : 6; endfunction
  function automatic int span(int p, int n, int d); return p * n * d; endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 4; i++) begin pc[i] = 0; last[i] = -1; end
  endtask

  task automatic wr_at(input logic [2:0] s, input logic [15:0] d, input int t);
    @(negedge clk);
    while (cyc < t - 1) @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wcyc = cyc;
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    wr_at(s, d, 0);
  endtask

  task automatic wait_until(int t);
    @(negedge clk);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic stop_all();
    wr(3'd2, 16'h0000);
    wr(3'd4, 16'h0000);
  endtask

  initial begin
    int w, d;
    void'($urandom(32'd2417));
    clr();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    check(pc[0] + pc[1] + pc[2] + pc[3] == 0, "R1 no irq after reset", pc[0] + pc[1] + pc[2] + pc[3], 0);
    check({irq_t0a, irq_t0b, irq_t1a, irq_t1b} == 4'b0, "R1 outputs low", {irq_t0a, irq_t0b, irq_t1a, irq_t1b}, 0);

    prescale = 8'd2;
    wr(3'd0, 16'd3); clr();
    wr(3'd2, 16'h0081); w = wcyc;
    wait_until(w + 172);
    check(last[0] == w + span(2, 3, 12), "R2 one-shot div12 time", last[0] - w, span(2, 3, 12));
    check(pc[0] == 1, "R2 one-shot single pulse", pc[0], 1);

    prescale = 8'd1;
    wr(3'd0, 16'd2); clr();
    wr(3'd2, 16'h00C1); w = wcyc;
    wait_until(w + 300);
    check(last[0] == w + 256, "R2 one-shot div128 time", last[0] - w, 256);

    wr(3'd1, 16'd5); wr(3'd0, 16'd5); clr();
    wr(3'd2, 16'h00A1); w = wcyc;
    wait_until(w + 100);
    check(last[0] == w + 60 && last[1] == w + 60, "R3 both delays same cycle", last[1] - w, 60);
    check(pc[0] == 1 && pc[1] == 1, "R3 one pulse each", pc[1], 1);
    clr();
    wr(3'd2, 16'h0031); w = wcyc;
    wait_until(w + 700);
    check(last[1] == w + 640, "R3 second delay div128", last[1] - w, 640);
    check(pc[0] == 0, "R3 first delay idle when bit7 clear", pc[0], 0);

    wr(3'd1, 16'd4); clr();
    wr(3'd2, 16'h0080); w = wcyc;
    wait_until(w + 77);
    check(pc[0] == 3 && last[0] == w + 72, "R4 interval period 24", last[0] - w, 72);
    check(pc[1] == 0, "R4 second line silent", pc[1], 0);
    wr(3'd2, 16'h0000); clr();
    wait_until(wcyc + 200);
    check(pc[0] == 0, "R6 stopped interval silent", pc[0], 0);

    wr(3'd1, 16'd2); clr();
    wr(3'd2, 16'h00C0); w = wcyc;
    wait_until(w + 517);
    check(pc[0] == 2 && last[0] == w + 512, "R4 interval div128", last[0] - w, 512);
    wr(3'd2, 16'h0000);

    wr(3'd1, 16'd4); clr();
    wr(3'd2, 16'h0080); w = wcyc;
    wr_at(3'd2, 16'h0000, w + 24);
    check(wcyc == w + 24, "R6 write aligned to expiry", wcyc - w, 24);
    wait_until(w + 120);
    check(pc[0] == 0, "R6 stop on expiry edge wins", pc[0], 0);
    clr();
    wr(3'd2, 16'h0080); w = wcyc;
    wr_at(3'd2, 16'h0080, w + 24);
    wait_until(w + 50);
    check(pc[0] == 1 && last[0] == w + 48, "R6 restart on expiry edge", last[0] - w, 48);
    wr(3'd2, 16'h0000);

    wr(3'd0, 16'd0); clr();
    wr(3'd2, 16'h0081);
    wr(3'd1, 16'd0);
    wr(3'd2, 16'h00A1);
    wr(3'd2, 16'h0080);
    wr(3'd3, 16'd0);
    wr(3'd4, 16'h0080);
    wait_until(wcyc + 400);
    check(pc[0] + pc[1] + pc[2] == 0, "R5 zero never starts", pc[0] + pc[1] + pc[2], 0);

    clr();
    wr(3'd3, 16'd2); w = wcyc;
    wait_until(w + 14);
    check(pc[2] == 1 && last[2] == w + 12, "R8 zero-to-nonzero starts timer1", last[2] - w, 12);
    wr_at(3'd3, 16'd5, w + 16);
    wait_until(w + 60);
    check(pc[2] == 3 && last[2] == w + 54, "R10 new modulus at next reload", last[2] - w, 54);

    wr(3'd4, 16'h0000);
    wr(3'd3, 16'd3); clr();
    wr(3'd4, 16'h00BF); w = wcyc;
    wait_until(w + 57);
    check(pc[2] == 3 && last[2] == w + 54, "R7 timer1 period div6", last[2] - w, 54);
    check(pc[3] == 3 && last[3] == w + 54, "R7 second request", last[3] - w, 54);
    wr(3'd4, 16'h0000);
    wr(3'd3, 16'd1); clr();
    wr(3'd4, 16'h00C0); w = wcyc;
    wait_until(w + 259);
    check(pc[2] == 2 && last[2] == w + 256, "R7 timer1 div128", last[2] - w, 256);
    wr(3'd4, 16'h0000);

    for (int k = 0; k < 12; k++) begin
      int p, n;
      bit b, om;
      stop_all();
      om = 1'($urandom % 2);
      p = 1 + int'($urandom % 3);
      n = 1 + int'($urandom % 6);
      b = 1'($urandom % 2);
      prescale = 8'(p);
      if (om) begin
        wr(3'd0, 16'(n)); clr();
        wr(3'd2, b ? 16'h00C1 : 16'h0081); w = wcyc;
        d = span(p, n, os_div(b));
        wait_until(w + d + 20);
        check(pc[0] == 1 && last[0] == w + d, "R2 random one-shot", last[0] - w, d);
      end else begin
        wr(3'd1, 16'(n)); clr();
        wr(3'd2, b ? 16'h00C0 : 16'h0080); w = wcyc;
        d = span(p, n, iv_div(b));
        wait_until(w + 2 * d + 2);
        check(pc[0] == 2 && last[0] == w + 2 * d, "R4 random interval", last[0] - w, 2 * d);
      end
    end

    for (int k = 0; k < 4; k++) begin
      int p, n;
      bit b;
      stop_all();
      p = 1 + int'($urandom % 3);
      n = 1 + int'($urandom % 5);
      b = 1'($urandom % 2);
      prescale = 8'(p);
      wr(3'd3, 16'(n)); clr();
      wr(3'd4, b ? 16'h00C0 : 16'h0080); w = wcyc;
      d = span(p, n, iv_div(b));
      wait_until(w + 2 * d + 2);
      check(pc[2] == 2 && pc[3] == 2 && last[3] == w + 2 * d, "R7 random timer1", last[3] - w, 2 * d);
    end
    stop_all();

    check(wide == 0, "R9 single-cycle pulses", wide, 0);
    check(pairerr == 0, "R7 paired requests coincide", pairerr, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule